// File: doc/BRIEF.md
# Handshaked Iterative GCD Unit

This block computes the greatest common divisor of two unsigned operands by repeated swapping and subtraction. It takes one step per clock. A caller offers an operand pair on a valid/ready input port. The block captures the pair and iterates until the second working value reaches zero. It then presents the first working value on a valid/ready result port until the consumer takes it.

Only one pair is in flight at a time. The input port is ready only while the unit is idle. Once a result has been accepted, the unit returns to idle and can take a new pair. The operand width is a parameter with a default of 16 bits.

Inside, a control state machine (idle, compute, done) steers a datapath through a small struct of strobes. The datapath holds two working registers, a less-than comparator, a zero detector on the second register and a subtractor.

Top module: `gcd_engine`

## Requirements
- R1: After a synchronous reset, including one applied in the middle of a computation, `opReady` is 1 and `resValid` is 0 in the cycle that follows.
- R2: An operand pair is captured only on a clock edge where `opValid` and `opReady` are both 1. From the next cycle, `opReady` stays 0 until the result has been handed over.
- R3: For operands a and b that are both nonzero, `resData` equals gcd(a, b) when `resValid` rises. For example, operands 27 and 15 give 3.
- R4: If both operands are zero, the result is 0. If exactly one operand is zero, the result is the other operand.
- R5: While `resValid` is 1 and `resReady` is 0, `resValid` stays 1 and `resData` keeps its value.
- R6: After a clock edge where `resValid` and `resReady` are both 1, `resValid` is 0 and `opReady` is 1.
- R7: `opReady` and `resValid` are never 1 in the same cycle. Values on `opValid`, `opA` and `opB` while the unit is busy have no effect on the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operand pair offered |
| opReady | output | 1 | Unit idle and able to capture a pair |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Consumer takes the result |
| resData | output | WIDTH | Greatest common divisor |

## Verification
Two events can meet in one cycle: a result being handed over and a new operand pair being offered. The bench holds `opValid` high with unrelated operand values for the whole busy period, including the cycle in which `resReady` completes the output handshake. It then checks that the result it already received is the correct GCD, and that `opReady` only comes back one cycle after the handover. The bench sweeps every operand pair of a 5-bit build and stalls the consumer for a varying number of cycles. Each result is compared with a GCD computed in the bench by remainder division.

// File: rtl/gcd_engine_pkg.sv
package gcd_engine_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic swap;
    logic sub;
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_DONE = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/gcd_engine_dpath.sv
module gcd_engine_dpath
  import gcd_engine_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  dpCtrl_t          ctrl,
  input  logic [WIDTH-1:0] inA,
  input  logic [WIDTH-1:0] inB,
  output logic             aLtB,
  output logic             bZero,
  output logic [WIDTH-1:0] valA
);

  logic [WIDTH-1:0] regA;
  logic [WIDTH-1:0] regB;
  logic [WIDTH-1:0] diff;

  assign aLtB  = regA < regB;
  assign bZero = regB == '0;
  assign diff  = regA - regB;
  assign valA  = regA;

  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      regA <= inA;
      regB <= inB;
    end else if (ctrl.swap) begin
      regA <= regB;
      regB <= regA;
    end else if (ctrl.sub) begin
      regA <= diff;
    end
  end

endmodule

// File: rtl/gcd_engine_ctrl.sv
module gcd_engine_ctrl
  import gcd_engine_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    opValid,
  output logic    opReady,
  output logic    resValid,
  input  logic    resReady,
  input  logic    aLtB,
  input  logic    bZero,
  output dpCtrl_t ctrl
);

  ctrlState_t state;
  ctrlState_t stateNext;

  assign opReady  = state == ST_IDLE;
  assign resValid = state == ST_DONE;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (opValid) begin
          ctrl.load = 1'b1;
          stateNext = ST_CALC;
        end
      end
      ST_CALC: begin
        if (aLtB) begin
          ctrl.swap = 1'b1;
        end else if (!bZero) begin
          ctrl.sub = 1'b1;
        end else begin
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        if (resReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
  import gcd_engine_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  output logic             opReady,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             resValid,
  input  logic             resReady,
  output logic [WIDTH-1:0] resData
);

  dpCtrl_t ctrl;
  logic    aLtB;
  logic    bZero;

  gcd_engine_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opValid  (opValid),
    .opReady  (opReady),
    .resValid (resValid),
    .resReady (resReady),
    .aLtB     (aLtB),
    .bZero    (bZero),
    .ctrl     (ctrl)
  );

  gcd_engine_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk   (clk),
    .ctrl  (ctrl),
    .inA   (opA),
    .inB   (opB),
    .aLtB  (aLtB),
    .bZero (bZero),
    .valA  (resData)
  );

endmodule

// File: rtl/gcd_engine_check.sv
module gcd_engine_check #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             opValid,
  input logic             opReady,
  input logic             resValid,
  input logic             resReady,
  input logic [WIDTH-1:0] resData
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (opReady && !resValid));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (opValid && opReady) |=> !opReady);

  assert_hold_result_R5: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resReady) |=> (resValid && $stable(resData)));

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (resValid && resReady) |=> (!resValid && opReady));

  assert_ports_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(opReady && resValid));

endmodule

bind gcd_engine gcd_engine_check #(.WIDTH(WIDTH)) u_check (
  .clk      (clk),
  .rst      (rst),
  .opValid  (opValid),
  .opReady  (opReady),
  .resValid (resValid),
  .resReady (resReady),
  .resData  (resData)
);

// File: tb/gcd_engine_test.sv
`timescale 1ns/1ps
module gcd_engine_test;

  localparam int W = 5;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         opValid = 1'b0;
  logic         opReady;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         resValid;
  logic         resReady = 1'b0;
  logic [W-1:0] resData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  gcd_engine #(.WIDTH(W)) uut (
    .clk      (clk),
    .rst      (rst),
    .opValid  (opValid),
    .opReady  (opReady),
    .opA      (opA),
    .opB      (opB),
    .resValid (resValid),
    .resReady (resReady),
    .resData  (resData)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 180000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 180000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int refGcd(int a, int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runPair(int a, int b, int stall, bit junk);
    int n = 0;
    int expv = refGcd(a, b);
    string tag = (a == 0 || b == 0) ? "R4" : "R3";
    @(negedge clk);
    opA = W'(a); opB = W'(b); opValid = 1'b1;
    check(opReady == 1'b1, "R2 ready in idle", int'(opReady), 1);
    @(negedge clk);
    if (junk) begin
      opA = ~W'(a); opB = W'(a ^ b ^ 7);  // R7 inputs while busy
    end else begin
      opValid = 1'b0;
    end
    check(opReady == 1'b0, "R2 busy after capture", int'(opReady), 0);
    while (!resValid && n < 200) begin
      @(negedge clk);
      n++;
      if (!resValid) check(opReady == 1'b0, "R7 busy no ready", int'(opReady), 0);
    end
    check(resValid == 1'b1, "R3 result arrives", int'(resValid), 1);
    check(int'(resData) == expv, tag, int'(resData), expv);
    check(opReady == 1'b0, "R7 exclusive", int'(opReady), 0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(resValid && int'(resData) == expv, "R5 hold", int'(resData), expv);
    end
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    opValid = 1'b0;
    check(!resValid && opReady, "R6 release", int'({resValid, opReady}), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(opReady == 1'b1, "R1 reset ready", int'(opReady), 1);
    check(resValid == 1'b0, "R1 reset valid", int'(resValid), 0);

    runPair(27, 15, 2, 1'b0);   // R3 named example
    runPair(0, 0, 0, 1'b0);     // R4
    runPair(0, 12, 1, 1'b0);    // R4
    runPair(20, 0, 1, 1'b1);    // R4 with busy inputs

    // R1: reset in the middle of a computation
    @(negedge clk);
    opA = W'(31); opB = W'(1); opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(opReady && !resValid, "R1 mid reset", int'({opReady, resValid}), 2);

    for (int a = 0; a <= MAXV; a++) begin
      for (int b = 0; b <= MAXV; b++) begin
        runPair(a, b, (a + b) % 3, ((a ^ b) & 1) == 1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule